// File: doc/BRIEF.md
# Deterministic Hardware Thread Slot Scheduler

This block shares one in-order core among up to four hardware threads at fixed, repeatable rates. A short slot table says which thread owns each clock issue slot. The table is stepped through in a loop of one to four entries. Even patterns give one, two or four threads at full, half or quarter rate. Uneven patterns such as aab, aaab, abc or abac give some threads a larger share. The table is rewritten only at the loop boundary, so the slot timing of every thread is always known in advance.

Each thread keeps its own program counter and its own page select into an 8K-word local memory that is split into four 2K-word pages. The core receives the owner of the current slot, that thread's PC and the base of its page. It reports back any page jump or cross-page move made by the instruction in that slot. The block also maps the source and destination operand addresses to physical addresses. A small I/O window at the top of every page always maps to one shared set of physical I/O registers. Threads are started and stopped through indexed requests that carry a core number and a thread number. A stopped thread keeps its slots, and those slots are marked as bubbles.

Top module: `task_slot_sched`

## Requirements
- R1: After reset, only thread 0 runs, with PC 0 and page 0. All four slot entries are 0 and the pattern length is 4. Threads 1 to 3 are stopped.
- R2: The slot owner `issue_tid_o` steps through slot entries 0 to L-1 and then returns to entry 0, where L = `cfg_len_i`+1. Entry k is `cfg_slots_i[2k+1:2k]`. Any entry may repeat, so uneven patterns are allowed.
- R3: A pattern written with `cfg_we_i` is first used at the next return to entry 0 that follows the write edge. If the write happens in the cycle of the last entry, it is used from the very next cycle. Until then the old pattern continues. If several writes come before the boundary, the last one is used.
- R4: Each slot in which the owner is running and takes no jump advances that thread's PC by 1, modulo 2048. The thread's page does not change.
- R5: When `jmp_i` is high in a running thread's slot, the thread's PC is loaded from `jmp_pc_i` and its page from `jmp_page_i`. `page_base_o` is always the owner's page times 2048.
- R6: An accepted stop clears the thread's run flag. From the next cycle, that thread's slots show `issue_run_o`=0 and its PC and page stay frozen. The slot pattern, and with it the timing of all other threads, is unchanged.
- R7: An accepted start sets the run flag and loads the PC and page from `start_pc_i` and `start_page_i`. The thread issues at its next slot. A start wins over the PC advance or jump of the same thread in the same cycle.
- R8: Start and stop requests are accepted only when `req_core_i` equals the parameter CORE_ID (default 2). If a start and a stop in the same cycle name the same thread, the stop wins and nothing is loaded.
- R9: Operand physical address = page*2048 + address. Without `xmove_i`, both operands use the owner's page. With `xmove_i`, `xmove_dir_i`=0 puts the source on `xmove_page_i`, and `xmove_dir_i`=1 puts the destination on it. The other operand stays on the owner's page.
- R10: Operand addresses 2032 to 2047 form the I/O window. They map to 3*2048 + address whatever page applies, and they raise `src_io_o` or `dst_io_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write new slot pattern |
| cfg_slots_i | input | 8 | Four 2-bit slot entries, entry k at bits 2k+1:2k |
| cfg_len_i | input | 2 | Pattern length minus one |
| req_core_i | input | 3 | Core number carried by start and stop requests |
| start_i | input | 1 | Thread start request |
| start_tid_i | input | 2 | Thread to start |
| start_pc_i | input | 11 | Start PC |
| start_page_i | input | 2 | Start page |
| stop_i | input | 1 | Thread stop request |
| stop_tid_i | input | 2 | Thread to stop |
| jmp_i | input | 1 | Page jump by the instruction in this slot |
| jmp_page_i | input | 2 | Jump target page |
| jmp_pc_i | input | 11 | Jump target PC |
| xmove_i | input | 1 | Cross-page move by this instruction |
| xmove_dir_i | input | 1 | 0: source on the named page, 1: destination on the named page |
| xmove_page_i | input | 2 | Named page for the cross-page operand |
| src_addr_i | input | 11 | Source operand address within its page |
| dst_addr_i | input | 11 | Destination operand address within its page |
| issue_tid_o | output | 2 | Owner of the current slot |
| issue_run_o | output | 1 | 1: real issue, 0: bubble (owner stopped) |
| issue_pc_o | output | 11 | Owner's PC |
| page_base_o | output | 13 | Owner's page base address |
| src_phys_o | output | 13 | Source physical address |
| dst_phys_o | output | 13 | Destination physical address |
| src_io_o | output | 1 | Source falls in the I/O window |
| dst_io_o | output | 1 | Destination falls in the I/O window |

## Verification
Two functions can act on the same thread in one cycle. A start request (or a stop) can name the thread that owns the current slot while that thread's instruction makes a jump. The bench sets up a two-entry pattern, waits for the target thread's slot, and then raises start and jump together. It expects the start PC and start page, not the jump target, at that thread's next slot. It also raises a stop and a start for one thread in the same cycle and expects the thread to remain stopped with its old PC.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int unsigned IO_WORDS_DEF = 16;
  localparam logic [1:0]  IO_PAGE_DEF  = 2'd3;
  typedef enum logic {XM_SRC = 1'b0, XM_DST = 1'b1} xmove_dir_e;
endpackage

// File: rtl/tss_slot_seq.sv
module tss_slot_seq #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned TID_W = 2,
  localparam int unsigned LEN_W = $clog2(SLOTS),
  localparam int unsigned TBL_W = SLOTS * TID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [TBL_W-1:0] cfg_slots_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  output logic [TID_W-1:0] tid_o,
  output logic [LEN_W-1:0] slot_o,
  output logic             wrap_o
);
  logic [TBL_W-1:0] tbl_q, ptbl_q;
  logic [LEN_W-1:0] len_q, plen_q, slot_q;
  logic             pend_q;

  assign wrap_o = (slot_q == len_q);
  assign slot_o = slot_q;
  assign tid_o  = tbl_q[slot_q*TID_W +: TID_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q  <= '0;
      len_q  <= LEN_W'(SLOTS - 1);
      ptbl_q <= '0;
      plen_q <= '0;
      pend_q <= 1'b0;
      slot_q <= '0;
    end else begin
      if (cfg_we_i) begin
        ptbl_q <= cfg_slots_i;
        plen_q <= cfg_len_i;
        pend_q <= 1'b1;
      end
      if (wrap_o) begin
        slot_q <= '0;
        // swap only at the loop boundary
        if (cfg_we_i) begin
          tbl_q  <= cfg_slots_i;
          len_q  <= cfg_len_i;
          pend_q <= 1'b0;
        end else if (pend_q) begin
          tbl_q  <= ptbl_q;
          len_q  <= plen_q;
          pend_q <= 1'b0;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tss_thread_bank.sv
module tss_thread_bank #(
  parameter int unsigned TID_W  = 2,
  parameter int unsigned PC_W   = 11,
  parameter int unsigned PAGE_W = 2,
  localparam int unsigned NTHR  = 1 << TID_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TID_W-1:0]       issue_tid_i,
  input  logic                   jmp_i,
  input  logic [PAGE_W-1:0]      jmp_page_i,
  input  logic [PC_W-1:0]        jmp_pc_i,
  input  logic                   start_ok_i,
  input  logic [TID_W-1:0]       start_tid_i,
  input  logic [PC_W-1:0]        start_pc_i,
  input  logic [PAGE_W-1:0]      start_page_i,
  input  logic                   stop_ok_i,
  input  logic [TID_W-1:0]       stop_tid_i,
  output logic [NTHR-1:0]        run_o,
  output logic [NTHR*PC_W-1:0]   pc_o,
  output logic [NTHR*PAGE_W-1:0] page_o
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic              run_q;
    logic [PC_W-1:0]   pc_q;
    logic [PAGE_W-1:0] page_q;
    logic              stop_hit, start_hit, issue_hit;

    assign stop_hit  = stop_ok_i && (stop_tid_i == TID_W'(t));
    assign start_hit = start_ok_i && (start_tid_i == TID_W'(t)) && !stop_hit;
    assign issue_hit = run_q && (issue_tid_i == TID_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q  <= 1'(t == 0);
        pc_q   <= '0;
        page_q <= '0;
      end else if (stop_hit) begin
        run_q <= 1'b0;
      end else if (start_hit) begin
        run_q  <= 1'b1;
        pc_q   <= start_pc_i;
        page_q <= start_page_i;
      end else if (issue_hit) begin
        if (jmp_i) begin
          pc_q   <= jmp_pc_i;
          page_q <= jmp_page_i;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end

    assign run_o[t]                    = run_q;
    assign pc_o[t*PC_W +: PC_W]        = pc_q;
    assign page_o[t*PAGE_W +: PAGE_W]  = page_q;
  end
endmodule

// File: rtl/tss_addr_map.sv
module tss_addr_map #(
  parameter int unsigned PC_W     = 11,
  parameter int unsigned PAGE_W   = 2,
  parameter int unsigned IO_WORDS = 16,
  parameter logic [PAGE_W-1:0] IO_PAGE = '1,
  localparam int unsigned ADDR_W  = PC_W + PAGE_W,
  localparam logic [PC_W-1:0] IO_BASE = PC_W'((1 << PC_W) - IO_WORDS)
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PC_W-1:0]   addr_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              io_o
);
  always_comb begin
    io_o   = (addr_i >= IO_BASE);
    phys_o = io_o ? {IO_PAGE, addr_i} : {page_i, addr_i};
  end
endmodule

// File: rtl/task_slot_sched.sv
module task_slot_sched
  import tss_pkg::*;
#(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned TID_W    = 2,
  parameter int unsigned PC_W     = 11,
  parameter int unsigned PAGE_W   = 2,
  parameter int unsigned CORE_W   = 3,
  parameter logic [CORE_W-1:0] CORE_ID = 3'd2,
  parameter int unsigned IO_WORDS = IO_WORDS_DEF,
  localparam int unsigned NTHR    = 1 << TID_W,
  localparam int unsigned LEN_W   = $clog2(SLOTS),
  localparam int unsigned TBL_W   = SLOTS * TID_W,
  localparam int unsigned ADDR_W  = PC_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TBL_W-1:0]  cfg_slots_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic              start_i,
  input  logic [TID_W-1:0]  start_tid_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic              stop_i,
  input  logic [TID_W-1:0]  stop_tid_i,
  input  logic              jmp_i,
  input  logic [PAGE_W-1:0] jmp_page_i,
  input  logic [PC_W-1:0]   jmp_pc_i,
  input  logic              xmove_i,
  input  logic              xmove_dir_i,
  input  logic [PAGE_W-1:0] xmove_page_i,
  input  logic [PC_W-1:0]   src_addr_i,
  input  logic [PC_W-1:0]   dst_addr_i,
  output logic [TID_W-1:0]  issue_tid_o,
  output logic              issue_run_o,
  output logic [PC_W-1:0]   issue_pc_o,
  output logic [ADDR_W-1:0] page_base_o,
  output logic [ADDR_W-1:0] src_phys_o,
  output logic [ADDR_W-1:0] dst_phys_o,
  output logic              src_io_o,
  output logic              dst_io_o
);
  logic [LEN_W-1:0]       seq_slot;
  logic                   seq_wrap;
  logic                   start_ok, stop_ok;
  logic [NTHR-1:0]        run_vec;
  logic [NTHR*PC_W-1:0]   pc_flat;
  logic [NTHR*PAGE_W-1:0] page_flat;
  logic [PAGE_W-1:0]      cur_page, src_page, dst_page;

  assign start_ok = start_i && (req_core_i == CORE_ID);
  assign stop_ok  = stop_i && (req_core_i == CORE_ID);

  tss_slot_seq #(.SLOTS(SLOTS), .TID_W(TID_W)) u_seq (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_slots_i, .cfg_len_i,
    .tid_o(issue_tid_o), .slot_o(seq_slot), .wrap_o(seq_wrap)
  );

  tss_thread_bank #(.TID_W(TID_W), .PC_W(PC_W), .PAGE_W(PAGE_W)) u_bank (
    .clk_i, .rst_ni,
    .issue_tid_i(issue_tid_o), .jmp_i, .jmp_page_i, .jmp_pc_i,
    .start_ok_i(start_ok), .start_tid_i, .start_pc_i, .start_page_i,
    .stop_ok_i(stop_ok), .stop_tid_i,
    .run_o(run_vec), .pc_o(pc_flat), .page_o(page_flat)
  );

  assign cur_page    = page_flat[issue_tid_o*PAGE_W +: PAGE_W];
  assign issue_pc_o  = pc_flat[issue_tid_o*PC_W +: PC_W];
  assign issue_run_o = run_vec[issue_tid_o];
  assign page_base_o = {cur_page, {PC_W{1'b0}}};

  assign src_page = (xmove_i && xmove_dir_i == XM_SRC) ? xmove_page_i : cur_page;
  assign dst_page = (xmove_i && xmove_dir_i == XM_DST) ? xmove_page_i : cur_page;

  tss_addr_map #(.PC_W(PC_W), .PAGE_W(PAGE_W), .IO_WORDS(IO_WORDS),
                 .IO_PAGE(PAGE_W'(IO_PAGE_DEF))) u_src_map (
    .page_i(src_page), .addr_i(src_addr_i), .phys_o(src_phys_o), .io_o(src_io_o)
  );

  tss_addr_map #(.PC_W(PC_W), .PAGE_W(PAGE_W), .IO_WORDS(IO_WORDS),
                 .IO_PAGE(PAGE_W'(IO_PAGE_DEF))) u_dst_map (
    .page_i(dst_page), .addr_i(dst_addr_i), .phys_o(dst_phys_o), .io_o(dst_io_o)
  );
endmodule

// File: rtl/task_slot_sched_chk.sv
module task_slot_sched_chk #(
  parameter int unsigned TID_W    = 2,
  parameter int unsigned PC_W     = 11,
  parameter int unsigned PAGE_W   = 2,
  parameter int unsigned LEN_W    = 2,
  parameter int unsigned IO_WORDS = 16,
  localparam int unsigned NTHR    = 1 << TID_W,
  localparam int unsigned ADDR_W  = PC_W + PAGE_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [TID_W-1:0]       issue_tid_o,
  input logic                   issue_run_o,
  input logic                   jmp_i,
  input logic [PAGE_W-1:0]      jmp_page_i,
  input logic                   start_ok,
  input logic                   stop_ok,
  input logic [TID_W-1:0]       start_tid_i,
  input logic [TID_W-1:0]       stop_tid_i,
  input logic [NTHR-1:0]        run_vec,
  input logic [NTHR*PC_W-1:0]   pc_flat,
  input logic [NTHR*PAGE_W-1:0] page_flat,
  input logic [LEN_W-1:0]       seq_slot,
  input logic                   seq_wrap,
  input logic [PC_W-1:0]        src_addr_i,
  input logic [PC_W-1:0]        dst_addr_i,
  input logic [ADDR_W-1:0]      src_phys_o,
  input logic [ADDR_W-1:0]      dst_phys_o
);
  localparam logic [PC_W-1:0] IO_BASE = PC_W'((1 << PC_W) - IO_WORDS);

  a_r2_slot_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_wrap |=> (seq_slot == '0));

  a_r4_pc_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_run_o && !jmp_i && !start_ok && !stop_ok) |=>
      (pc_flat[$past(issue_tid_o)*PC_W +: PC_W] ==
       PC_W'($past(pc_flat[issue_tid_o*PC_W +: PC_W]) + 1'b1)));

  a_r5_jump_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_run_o && jmp_i && !start_ok && !stop_ok) |=>
      (page_flat[$past(issue_tid_o)*PAGE_W +: PAGE_W] == $past(jmp_page_i)));

  a_r6_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ok |=> !run_vec[$past(stop_tid_i)]);

  a_r7_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && !(stop_ok && stop_tid_i == start_tid_i)) |=> run_vec[$past(start_tid_i)]);

  a_r10_io_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_addr_i == dst_addr_i && src_addr_i >= IO_BASE) |-> (src_phys_o == dst_phys_o));
endmodule

bind task_slot_sched task_slot_sched_chk #(
  .TID_W(TID_W), .PC_W(PC_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W), .IO_WORDS(IO_WORDS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_tid_o(issue_tid_o), .issue_run_o(issue_run_o),
  .jmp_i(jmp_i), .jmp_page_i(jmp_page_i), .start_ok(start_ok), .stop_ok(stop_ok),
  .start_tid_i(start_tid_i), .stop_tid_i(stop_tid_i), .run_vec(run_vec),
  .pc_flat(pc_flat), .page_flat(page_flat), .seq_slot(seq_slot), .seq_wrap(seq_wrap),
  .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
  .src_phys_o(src_phys_o), .dst_phys_o(dst_phys_o)
);

// File: tb/task_slot_sched_bench.sv
module task_slot_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CORE = 2;
  localparam int IO_BASE = 2032;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0; logic [7:0] cfg_slots_i = 0; logic [1:0] cfg_len_i = 0;
  logic [2:0] req_core_i = 3'(CORE);
  logic start_i = 0; logic [1:0] start_tid_i = 0; logic [10:0] start_pc_i = 0;
  logic [1:0] start_page_i = 0;
  logic stop_i = 0; logic [1:0] stop_tid_i = 0;
  logic jmp_i = 0; logic [1:0] jmp_page_i = 0; logic [10:0] jmp_pc_i = 0;
  logic xmove_i = 0, xmove_dir_i = 0; logic [1:0] xmove_page_i = 0;
  logic [10:0] src_addr_i = 0, dst_addr_i = 0;
  logic [1:0] issue_tid_o; logic issue_run_o; logic [10:0] issue_pc_o;
  logic [12:0] page_base_o, src_phys_o, dst_phys_o; logic src_io_o, dst_io_o;

  task_slot_sched u_task_slot_sched (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_tick = 0;
  bit finished = 0;
  int m_tbl[4], m_ptbl[4], m_len, m_plen, m_slot, m_pend;
  int m_run[4], m_pc[4], m_page[4];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int phys(input int pg, input int a);
    return (a >= IO_BASE) ? (3*2048 + a) : (pg*2048 + a);
  endfunction

  // compare outputs mid-cycle, then advance model at the edge
  task automatic tick(input string req);
    int tid, sp, dp;
    src_addr_i = (n_tick % 4 == 0) ? 11'(IO_BASE + n_tick % 16) : 11'((n_tick * 37) % 2048);
    dst_addr_i = (n_tick % 6 == 0) ? src_addr_i : 11'((n_tick * 53 + 7) % 2048);
    #1;
    tid = m_tbl[m_slot];
    sp = (xmove_i && !xmove_dir_i) ? int'(xmove_page_i) : m_page[tid];
    dp = (xmove_i && xmove_dir_i) ? int'(xmove_page_i) : m_page[tid];
    chk(int'(issue_tid_o) == tid, req, "slot owner", int'(issue_tid_o), tid);
    chk(int'(issue_run_o) == m_run[tid], req, "run flag", int'(issue_run_o), m_run[tid]);
    chk(int'(issue_pc_o) == m_pc[tid], "R4", "pc", int'(issue_pc_o), m_pc[tid]);
    chk(int'(page_base_o) == m_page[tid]*2048, "R5", "page base", int'(page_base_o), m_page[tid]*2048);
    chk(int'(src_phys_o) == phys(sp, int'(src_addr_i)), (src_addr_i >= IO_BASE) ? "R10" : "R9",
        "src phys", int'(src_phys_o), phys(sp, int'(src_addr_i)));
    chk(int'(dst_phys_o) == phys(dp, int'(dst_addr_i)), (dst_addr_i >= IO_BASE) ? "R10" : "R9",
        "dst phys", int'(dst_phys_o), phys(dp, int'(dst_addr_i)));
    @(posedge clk_i);
    begin
      bit sok, tok;
      sok = start_i && int'(req_core_i) == CORE;
      tok = stop_i && int'(req_core_i) == CORE;
      for (int t = 0; t < 4; t++) begin
        if (tok && int'(stop_tid_i) == t) m_run[t] = 0;
        else if (sok && int'(start_tid_i) == t) begin
          m_run[t] = 1; m_pc[t] = int'(start_pc_i); m_page[t] = int'(start_page_i);
        end else if (t == tid && m_run[t] == 1) begin
          if (jmp_i) begin m_pc[t] = int'(jmp_pc_i); m_page[t] = int'(jmp_page_i); end
          else m_pc[t] = (m_pc[t] + 1) % 2048;
        end
      end
      if (m_slot == m_len) begin
        m_slot = 0;
        if (cfg_we_i) begin
          for (int k = 0; k < 4; k++) m_tbl[k] = int'(cfg_slots_i[2*k +: 2]);
          m_len = int'(cfg_len_i); m_pend = 0;
        end else if (m_pend == 1) begin
          m_tbl = m_ptbl; m_len = m_plen; m_pend = 0;
        end
      end else begin
        m_slot++;
        if (cfg_we_i) begin
          for (int k = 0; k < 4; k++) m_ptbl[k] = int'(cfg_slots_i[2*k +: 2]);
          m_plen = int'(cfg_len_i); m_pend = 1;
        end
      end
    end
    @(negedge clk_i);
    n_tick++;
    cfg_we_i = 0; start_i = 0; stop_i = 0; jmp_i = 0; xmove_i = 0;
  endtask

  task automatic set_pat(input logic [7:0] s, input logic [1:0] l);
    cfg_we_i = 1; cfg_slots_i = s; cfg_len_i = l;
  endtask

  task automatic do_start(input int t, input int pc, input int pg);
    start_i = 1; start_tid_i = 2'(t); start_pc_i = 11'(pc); start_page_i = 2'(pg);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_tbl[k] = 0; m_ptbl[k] = 0; m_run[k] = (k == 0); m_pc[k] = 0; m_page[k] = 0;
    end
    m_len = 3; m_plen = 0; m_slot = 0; m_pend = 0;
    #(CLK_PERIOD*2);
    @(negedge clk_i); rst_ni = 1;
    // R1: reset state
    repeat (3) tick("R1");
    set_pat(8'hE4, 2'd3);          // abcd
    repeat (2) tick("R3");
    repeat (8) tick("R1");         // threads 1..3 show bubbles
    // R8: wrong core number ignored
    req_core_i = 3'd5; do_start(1, 99, 1); tick("R8");
    req_core_i = 3'd5; stop_i = 1; stop_tid_i = 0; tick("R8");
    req_core_i = 3'(CORE);
    repeat (8) tick("R8");
    // R7: start threads 1..3
    for (int t = 1; t < 4; t++) begin do_start(t, 100*t, t); tick("R7"); end
    repeat (8) tick("R7");
    // R2/R3 sweep of every table and length, with jumps and cross moves
    for (int code = 0; code < 256; code++) begin
      for (int l = 0; l < 4; l++) begin
        set_pat(8'(code), 2'(l));
        for (int c = 0; c < 9; c++) begin
          if ((n_tick % 5) == 2) begin
            jmp_i = 1; jmp_page_i = 2'(n_tick % 4); jmp_pc_i = 11'((n_tick * 13) % 2048);
          end
          if ((n_tick % 3) == 1) begin
            xmove_i = 1; xmove_dir_i = n_tick[0]; xmove_page_i = 2'((n_tick / 3) % 4);
          end
          if (c == 4 && (code % 7) == 3) set_pat(8'(~code), 2'(3 - l));
          tick((c == 0) ? "R3" : "R2");
        end
      end
    end
    // R6: stop thread 2 under abcd; others keep their slots
    set_pat(8'hE4, 2'd3);
    repeat (5) tick("R6");
    stop_i = 1; stop_tid_i = 2; tick("R6");
    repeat (12) tick("R6");
    do_start(2, 7, 0); tick("R7");
    repeat (4) tick("R7");
    // same-cycle collisions: start vs jump, stop vs start
    set_pat(8'h04, 2'd1);          // ab
    repeat (6) tick("R3");
    while (m_tbl[m_slot] != 1) tick("R2");
    do_start(1, 500, 2); jmp_i = 1; jmp_pc_i = 11'd700; jmp_page_i = 2'd3; tick("R7");
    repeat (4) tick("R7");
    stop_i = 1; stop_tid_i = 1; do_start(1, 900, 3); tick("R8");
    repeat (4) tick("R8");
    // R9: both cross-move directions while thread 0 owns the slot
    for (int d = 0; d < 2; d++) begin
      while (m_tbl[m_slot] != 0) tick("R2");
      xmove_i = 1; xmove_dir_i = 1'(d); xmove_page_i = 2'd2; tick("R9");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule